// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

The block gathers eight interrupt request lines into a single interrupt output for a processor. For every line it keeps three bits of state: a pending bit (the request is waiting to be acknowledged), an in-service bit (the request has been acknowledged and is waiting for end-of-interrupt) and a mask bit. Each line is edge- or level-triggered, chosen by a configuration bit. A priority resolver picks the winning line, either in a fixed order or in a rotating order. The output is raised only when that winner outranks every level already in service, so interrupts nest correctly.

The processor answers with a one-cycle acknowledge strobe. One cycle later the block returns an 8-bit vector, made of the upper five bits of a programmable base and the 3-bit number of the winning line. If the line that raised the request has gone away by then, the block answers with the line-7 vector and changes no state. Lines that are flagged as having a downstream controller attached also drive out their 3-bit cascade identifier with the vector.

A small register port sets the mask, the trigger modes, the priority and auto-EOI modes, the vector base and the cascade map. The same port accepts non-specific end-of-interrupt commands and reads back the pending and in-service state.

Top module: `prio_intc`

## Requirements
- R1: After reset: the mask register reads 0xFF, all other registers read 0, `int_o`, `vec_vld_o` and `cas_en_o` are 0, and the rotation pointer marks line 7 as lowest priority. The register addresses are 0 mask, 1 trigger (bit=1 level), 2 control (bit0 rotate, bit1 auto-EOI), 3 vector base, 4 cascade map, 5 write=EOI / read pending, 6 read in-service, 7 reads 0.
- R2: On an edge-triggered line, a rising edge sets its pending bit, and the bit stays set after the line falls. On a level-triggered line, the pending bit follows the line in every cycle. Acknowledging a line clears its pending bit.
- R3: A masked line still becomes pending but never raises `int_o`. Unmasking it raises `int_o` without a new edge.
- R4: In fixed mode line 0 has the highest priority and line 7 the lowest. `int_o` is 1 exactly when some unmasked pending line has higher priority than every in-service line.
- R5: An `ack_i` strobe yields `vec_vld_o`=1 for one cycle on the next clock, with `vec_o` = {base[7:3], winner index}. The winner's pending bit is cleared and, outside auto-EOI, its in-service bit is set.
- R6: If `int_o` is 0 when `ack_i` arrives, `vec_o` = {base[7:3], 3'b111}, no pending or in-service bit changes, and `cas_en_o` is 0.
- R7: Writing address 5 clears the in-service bit of highest current priority. It has no effect when no in-service bit is set.
- R8: With auto-EOI (control bit1) set, acknowledge sets no in-service bit, so the next pending line can interrupt at once.
- R9: With rotate (control bit0) set, the line cleared by an EOI becomes lowest priority, and priority runs upward from it modulo 8. With rotate and auto-EOI both set, the rotation happens at acknowledge instead.
- R10: On a granted acknowledge of a line whose cascade-map bit is 1, `cas_en_o`=1 and `cas_id_o` = the line number. Otherwise `cas_en_o`=0.
- R11: Writable registers read back what was written, except that the low three bits of the base and bits 7:2 of the control register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | 8 | Interrupt request lines, one per level |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Register read data (combinational from address) |
| int_o | output | 1 | Interrupt output to the processor |
| ack_i | input | 1 | One-cycle acknowledge strobe |
| vec_o | output | 8 | Vector returned for the last acknowledge |
| vec_vld_o | output | 1 | Vector valid, one cycle after acknowledge |
| cas_en_o | output | 1 | Cascade identifier valid |
| cas_id_o | output | 3 | Cascade identifier of the acknowledged line |

## Verification
The bench sweeps all 255 non-empty request patterns in fixed mode and services each pattern to empty. This catches a resolver that picks the wrong bit, or a controller that lets a lower line interrupt past an in-service one. It also sweeps all 256 mask values and a set of request patterns under rotation, checked against an arithmetic priority model. A pointer that fails to move after EOI would produce a wrong service order. A request that drops before acknowledge must produce the line-7 vector with no in-service bit. A design that grants anyway would leave a stuck in-service bit that blocks every later interrupt. Auto-EOI, preemption with nested EOI, the level/edge difference after the line drops, and cascade identifiers on flagged and unflagged lines are each checked at the ports.

// File: rtl/pic_pkg.sv
// Shared definitions of the interrupt controller: register address map.
// Assumes a 3-bit register address.
package pic_pkg;
    typedef enum logic [2:0] {
        A_MASK  = 3'd0,
        A_TRIG  = 3'd1,
        A_CTRL  = 3'd2,
        A_BASE  = 3'd3,
        A_SLAVE = 3'd4,
        A_EOI   = 3'd5,
        A_INSRV = 3'd6,
        A_NONE  = 3'd7
    } pic_addr_e;
endpackage

// File: rtl/pic_regs.sv
// Configuration registers of the interrupt controller and the read-back mux.
// Writes take effect on the clock edge. Address 5 write is a command (EOI
// strobe), not storage. Assumes N_IRQ <= DW and N_IRQ a power of two.
module pic_regs
    import pic_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int DW    = 8,
    localparam int IW   = $clog2(N_IRQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [2:0]       addr_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [N_IRQ-1:0] pend_i,
    input  logic [N_IRQ-1:0] isr_i,
    output logic [DW-1:0]    rdata_o,
    output logic [N_IRQ-1:0] mask_o,
    output logic [N_IRQ-1:0] lvl_o,
    output logic [N_IRQ-1:0] slave_o,
    output logic [DW-IW-1:0] base_o,
    output logic             rot_o,
    output logic             aeoi_o,
    output logic             eoi_o
);
    // Storage of the programmable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o  <= '1;
            lvl_o   <= '0;
            slave_o <= '0;
            base_o  <= '0;
            rot_o   <= 1'b0;
            aeoi_o  <= 1'b0;
        end else if (we_i) begin
            case (pic_addr_e'(addr_i))
                A_MASK:  mask_o  <= wdata_i[N_IRQ-1:0];
                A_TRIG:  lvl_o   <= wdata_i[N_IRQ-1:0];
                A_SLAVE: slave_o <= wdata_i[N_IRQ-1:0];
                A_BASE:  base_o  <= wdata_i[DW-1:IW];
                A_CTRL: begin
                    rot_o  <= wdata_i[0];
                    aeoi_o <= wdata_i[1];
                end
                default: ;
            endcase
        end
    end

    // End-of-interrupt command strobe
    assign eoi_o = we_i && (pic_addr_e'(addr_i) == A_EOI);

    // Read-back multiplexer
    always_comb begin
        case (pic_addr_e'(addr_i))
            A_MASK:  rdata_o = DW'(mask_o);
            A_TRIG:  rdata_o = DW'(lvl_o);
            A_CTRL:  rdata_o = DW'({aeoi_o, rot_o});
            A_BASE:  rdata_o = {base_o, {IW{1'b0}}};
            A_SLAVE: rdata_o = DW'(slave_o);
            A_EOI:   rdata_o = DW'(pend_i);
            A_INSRV: rdata_o = DW'(isr_i);
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/pic_req_latch.sv
// Request detection per line. Edge lines latch a rising edge until cleared.
// Level lines copy the input every cycle. A clear (acknowledge) wins over
// a set in the same cycle.
module pic_req_latch #(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_i,
    input  logic [N_IRQ-1:0] lvl_i,
    input  logic [N_IRQ-1:0] clr_i,
    output logic [N_IRQ-1:0] pend_o
);
    for (genvar g = 0; g < N_IRQ; g++) begin : g_line
        logic prev_q;
        logic pend_q;

        // Track previous level and update the pending bit of this line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                pend_q <= 1'b0;
            end else begin
                prev_q <= irq_i[g];
                if (clr_i[g])
                    pend_q <= 1'b0;
                else if (lvl_i[g])
                    pend_q <= irq_i[g];
                else if (irq_i[g] && !prev_q)
                    pend_q <= 1'b1;
            end
        end

        assign pend_o[g] = pend_q;
    end
endmodule

// File: rtl/pic_prio_res.sv
// Rotating-order priority resolver. The slot after low_i has rank 0
// (highest), and rank rises modulo N_IRQ. Reports the highest set bit, its
// rank, and rank N_IRQ when nothing is set. Assumes N_IRQ a power of two.
module pic_prio_res #(
    parameter int N_IRQ = 8,
    localparam int IW   = $clog2(N_IRQ)
) (
    input  logic [N_IRQ-1:0] req_i,
    input  logic [IW-1:0]    low_i,
    output logic             hit_o,
    output logic [IW-1:0]    idx_o,
    output logic [IW:0]      rank_o
);
    logic [IW-1:0] pos;

    // Scan from lowest to highest rank so the highest-ranked hit is kept
    always_comb begin
        hit_o  = 1'b0;
        idx_o  = '0;
        rank_o = (IW+1)'(N_IRQ);
        pos    = '0;
        for (int k = N_IRQ - 1; k >= 0; k--) begin
            pos = low_i + IW'(k + 1);
            if (req_i[pos]) begin
                hit_o  = 1'b1;
                idx_o  = pos;
                rank_o = (IW+1)'(k);
            end
        end
    end
endmodule

// File: rtl/prio_intc.sv
// Eight-line priority interrupt controller top. It combines the request
// latch, the configuration registers and two priority resolvers (pending
// and in-service). It answers a one-cycle acknowledge with a vector one
// clock later. The interrupt output is combinational from registered state.
module prio_intc #(
    parameter int N_IRQ = 8,
    parameter int DW    = 8,
    localparam int IW   = $clog2(N_IRQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_i,
    input  logic             cfg_we_i,
    input  logic [2:0]       cfg_addr_i,
    input  logic [DW-1:0]    cfg_wdata_i,
    output logic [DW-1:0]    cfg_rdata_o,
    output logic             int_o,
    input  logic             ack_i,
    output logic [DW-1:0]    vec_o,
    output logic             vec_vld_o,
    output logic             cas_en_o,
    output logic [IW-1:0]    cas_id_o
);
    localparam logic [N_IRQ-1:0] ONE = N_IRQ'(1);

    logic [N_IRQ-1:0] pend_q, isr_q, mask_q, lvl_q, slave_q;
    logic [DW-IW-1:0] base_q;
    logic             rot_q, aeoi_q, eoi_cmd;
    logic [IW-1:0]    ptr_q, lowest;
    logic             p_hit, i_hit, grant, take, eoi_do;
    logic [IW-1:0]    p_idx, i_idx;
    logic [IW:0]      p_rank, i_rank;
    logic [N_IRQ-1:0] win_oh, eoi_oh, ack_clr;

    pic_regs #(.N_IRQ(N_IRQ), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
        .wdata_i(cfg_wdata_i), .pend_i(pend_q), .isr_i(isr_q),
        .rdata_o(cfg_rdata_o), .mask_o(mask_q), .lvl_o(lvl_q),
        .slave_o(slave_q), .base_o(base_q), .rot_o(rot_q),
        .aeoi_o(aeoi_q), .eoi_o(eoi_cmd)
    );

    pic_req_latch #(.N_IRQ(N_IRQ)) u_req (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .lvl_i(lvl_q),
        .clr_i(ack_clr), .pend_o(pend_q)
    );

    pic_prio_res #(.N_IRQ(N_IRQ)) u_res_pend (
        .req_i(pend_q & ~mask_q), .low_i(lowest),
        .hit_o(p_hit), .idx_o(p_idx), .rank_o(p_rank)
    );

    pic_prio_res #(.N_IRQ(N_IRQ)) u_res_isr (
        .req_i(isr_q), .low_i(lowest),
        .hit_o(i_hit), .idx_o(i_idx), .rank_o(i_rank)
    );

    // Priority origin: fixed keeps the last line lowest
    assign lowest  = rot_q ? ptr_q : IW'(N_IRQ - 1);
    // Grant only when the pending winner outranks all in-service levels
    assign grant   = p_hit && (p_rank < i_rank);
    assign int_o   = grant;
    assign take    = ack_i && grant;
    assign eoi_do  = eoi_cmd && i_hit;
    assign win_oh  = ONE << p_idx;
    assign eoi_oh  = ONE << i_idx;
    assign ack_clr = take ? win_oh : '0;

    // In-service register: set on granted acknowledge, clear on EOI
    always_ff @(posedge clk) begin
        if (!rst_n)
            isr_q <= '0;
        else
            isr_q <= (isr_q & ~(eoi_do ? eoi_oh : '0))
                   | ((take && !aeoi_q) ? win_oh : '0);
    end

    // Rotation pointer: the serviced line becomes lowest priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= IW'(N_IRQ - 1);
        else if (eoi_do && rot_q)
            ptr_q <= i_idx;
        else if (take && aeoi_q && rot_q)
            ptr_q <= p_idx;
    end

    // Acknowledge response: vector, valid strobe and cascade identifier
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_o     <= '0;
            vec_vld_o <= 1'b0;
            cas_en_o  <= 1'b0;
            cas_id_o  <= '0;
        end else begin
            vec_vld_o <= ack_i;
            if (ack_i) begin
                vec_o    <= {base_q, (grant ? p_idx : {IW{1'b1}})};
                cas_en_o <= grant && slave_q[p_idx];
                cas_id_o <= grant ? p_idx : '0;
            end else begin
                cas_en_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pic_chk.sv
// Protocol checker for the interrupt controller, bound to the top module.
module pic_chk #(
    parameter int N_IRQ = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             int_o,
    input logic             ack_i,
    input logic             vec_vld,
    input logic             cas_en,
    input logic [N_IRQ-1:0] pend,
    input logic [N_IRQ-1:0] mask,
    input logic [N_IRQ-1:0] isr,
    input logic             aeoi
);
    // R3
    int_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> ((pend & ~mask) != '0));

    // R5
    ack_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> vec_vld);

    // R5
    no_stray_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> !vec_vld);

    // R5
    isr_grow_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> ((isr & ~$past(isr)) == '0));

    // R8
    aeoi_no_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aeoi |=> ((isr & ~$past(isr)) == '0));

    // R10
    cas_with_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cas_en |-> vec_vld);
endmodule

bind prio_intc pic_chk #(.N_IRQ(N_IRQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .int_o(int_o), .ack_i(ack_i),
    .vec_vld(vec_vld_o), .cas_en(cas_en_o), .pend(pend_q),
    .mask(mask_q), .isr(isr_q), .aeoi(aeoi_q)
);

// File: tb/test_prio_intc.sv
`timescale 1ns/100ps
module test_prio_intc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq = '0;
    logic       we = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wd = '0;
    logic [7:0] rdata;
    logic       int_o, ack = 1'b0;
    logic [7:0] vec;
    logic       vec_vld, cas_en;
    logic [2:0] cas_id;
    int         n_vec = 0, n_bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    prio_intc i_prio_intc (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .cfg_we_i(we),
        .cfg_addr_i(addr), .cfg_wdata_i(wd), .cfg_rdata_o(rdata),
        .int_o(int_o), .ack_i(ack), .vec_o(vec), .vec_vld_o(vec_vld),
        .cas_en_o(cas_en), .cas_id_o(cas_id)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); we = 1'b1; addr = a; wd = d;
        @(posedge clk); #1; we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a; #0.5; d = rdata;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk); irq = v;
        @(posedge clk); #1;
    endtask

    task automatic do_ack(output logic [7:0] v, output logic ce, output logic [2:0] ci);
        @(negedge clk); ack = 1'b1;
        @(posedge clk); #1;
        v = vec; ce = cas_en; ci = cas_id; ack = 1'b0;
        chk("R5 vec_vld", int'(vec_vld), 1);
    endtask

    // Highest-priority set bit when line `low` is lowest priority
    function automatic int pick(input logic [7:0] b, input int low);
        for (int k = 0; k < 8; k++) begin
            int q = (low + 1 + k) % 8;
            if (b[q]) return q;
        end
        return -1;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, v, rem, p;
        logic       ce;
        logic [2:0] ci;
        int         w, low;

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        chk("R1 int_o", int'(int_o), 0);
        chk("R1 vec_vld", int'(vec_vld), 0);
        chk("R1 cas_en", int'(cas_en), 0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), r);
            chk($sformatf("R1 reg %0d", a), int'(r), (a == 0) ? 8'hFF : 0);
        end

        // R11 read-back
        for (int a = 0; a < 5; a++) begin
            logic [7:0] d = 8'h5A ^ 8'(a * 8'h33);
            wr(3'(a), d);
            rd(3'(a), r);
            chk($sformatf("R11 reg %0d", a), int'(r),
                (a == 2) ? int'(d & 8'h03) : (a == 3) ? int'(d & 8'hF8) : int'(d));
        end
        wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h00); wr(4, 8'h00);

        // R4 R5 R7 fixed-priority sweep over all request patterns
        for (int pi = 1; pi < 256; pi++) begin
            p = 8'(pi);
            wr(3, {p[4:0], 3'b101});
            set_irq(p); set_irq(8'h00);
            rd(5, r); chk("R2 edge latch held", int'(r), int'(p));
            rem = p;
            while (rem != 0) begin
                w = pick(rem, 7);
                chk("R4 int_o raised", int'(int_o), 1);
                do_ack(v, ce, ci);
                chk("R5 vector", int'(v), int'({p[4:0], 3'(w)}));
                rem[w] = 1'b0;
                chk("R4 lower blocked by in-service", int'(int_o), 0);
                rd(6, r); chk("R5 in-service set", int'(r), 1 << w);
                wr(5, 8'h00);
                rd(6, r); chk("R7 eoi clears", int'(r), 0);
            end
        end

        // R4 R7 preemption and nested EOI
        wr(3, 8'h40);
        set_irq(8'h20); set_irq(8'h00);
        do_ack(v, ce, ci); chk("R5 vector line5", int'(v), 8'h45);
        set_irq(8'h04); set_irq(8'h00);
        chk("R4 higher preempts", int'(int_o), 1);
        do_ack(v, ce, ci); chk("R5 vector line2", int'(v), 8'h42);
        rd(6, r); chk("R5 nested in-service", int'(r), 8'h24);
        set_irq(8'h40); set_irq(8'h00);
        chk("R4 line6 blocked", int'(int_o), 0);
        wr(5, 8'h00);
        rd(6, r); chk("R7 clears highest in-service", int'(r), 8'h20);
        chk("R4 still blocked by line5", int'(int_o), 0);
        wr(5, 8'h00);
        chk("R4 line6 now granted", int'(int_o), 1);
        do_ack(v, ce, ci); chk("R5 vector line6", int'(v), 8'h46);
        wr(5, 8'h00);
        wr(5, 8'h00);
        rd(6, r); chk("R7 eoi on empty", int'(r), 0);

        // R3 masked edge request stays pending
        wr(0, 8'hFF);
        set_irq(8'h10); set_irq(8'h00);
        chk("R3 masked no int", int'(int_o), 0);
        rd(5, r); chk("R3 masked pending", int'(r), 8'h10);
        wr(0, 8'h00);
        chk("R3 unmask raises int", int'(int_o), 1);
        do_ack(v, ce, ci); chk("R3 vector line4", int'(v), 8'h44);
        wr(5, 8'h00);

        // R3 mask sweep with all level lines high
        wr(1, 8'hFF);
        set_irq(8'hFF);
        for (int m = 0; m < 256; m++) begin
            wr(0, 8'(m));
            chk("R3 int vs mask", int'(int_o), (m != 255) ? 1 : 0);
            if (m != 255) begin
                w = pick(~8'(m), 7);
                do_ack(v, ce, ci);
                chk("R3 masked winner", int'(v), 8'h40 | w);
                wr(5, 8'h00);
            end
        end
        set_irq(8'h00);
        wr(0, 8'h00);

        // R2 level follows, edge holds
        wr(1, 8'h01);
        set_irq(8'h03);
        rd(5, r); chk("R2 both pending", int'(r), 8'h03);
        set_irq(8'h00);
        rd(5, r); chk("R2 level drops, edge holds", int'(r), 8'h02);
        do_ack(v, ce, ci); chk("R2 vector line1", int'(v), 8'h41);
        rd(5, r); chk("R2 ack clears pending", int'(r), 0);
        wr(5, 8'h00);

        // R6 request vanishes before acknowledge
        wr(1, 8'h08);
        set_irq(8'h08);
        chk("R6 int raised", int'(int_o), 1);
        set_irq(8'h00);
        chk("R6 int dropped", int'(int_o), 0);
        do_ack(v, ce, ci);
        chk("R6 line7 vector", int'(v), 8'h47);
        chk("R6 no cascade", int'(ce), 0);
        rd(6, r); chk("R6 no in-service", int'(r), 0);
        wr(1, 8'h00);

        // R8 auto-EOI
        wr(2, 8'h02);
        set_irq(8'h21); set_irq(8'h00);
        do_ack(v, ce, ci); chk("R8 vector line0", int'(v), 8'h40);
        rd(6, r); chk("R8 no in-service", int'(r), 0);
        chk("R8 next interrupts at once", int'(int_o), 1);
        do_ack(v, ce, ci); chk("R8 vector line5", int'(v), 8'h45);
        chk("R8 all served", int'(int_o), 0);

        // R9 rotating priority with EOI
        wr(2, 8'h01);
        low = 7;
        for (int k = 0; k < 64; k++) begin
            p = 8'(k * 37 + 11);
            if (p == 0) continue;
            set_irq(p); set_irq(8'h00);
            rem = p;
            while (rem != 0) begin
                w = pick(rem, low);
                chk("R9 int raised", int'(int_o), 1);
                do_ack(v, ce, ci);
                chk("R9 rotated winner", int'(v), 8'h40 | w);
                rem[w] = 1'b0;
                wr(5, 8'h00);
                low = w;
            end
        end

        // R9 rotating priority with auto-EOI
        wr(2, 8'h03);
        for (int k = 0; k < 16; k++) begin
            p = 8'(k * 91 + 29);
            if (p == 0) continue;
            set_irq(p); set_irq(8'h00);
            rem = p;
            while (rem != 0) begin
                w = pick(rem, low);
                do_ack(v, ce, ci);
                chk("R9 auto-EOI rotated winner", int'(v), 8'h40 | w);
                rem[w] = 1'b0;
                low = w;
            end
        end
        wr(2, 8'h00);

        // R10 cascade identifiers
        wr(4, 8'hA5);
        for (int i = 0; i < 8; i++) begin
            set_irq(8'(1 << i)); set_irq(8'h00);
            do_ack(v, ce, ci);
            chk("R10 cascade enable", int'(ce), (8'hA5 >> i) & 1);
            if (ce) chk("R10 cascade id", int'(ci), i);
            chk("R10 vector", int'(v), 8'h40 | i);
            wr(5, 8'h00);
        end
        wr(1, 8'h01);
        set_irq(8'h01); set_irq(8'h00);
        do_ack(v, ce, ci);
        chk("R10 spurious no cascade", int'(ce), 0);
        chk("R6 spurious vector", int'(v), 8'h47);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule